// File: doc/BRIEF.md
# 100 Mb/s PCS Transmit Encoder

This block turns the 4-bit nibble stream of a media access controller into the three-level line code of a 100 Mb/s twisted-pair link. Everything runs from one 125 MHz clock. A divide-by-five phase counter produces `tx_clk_en`, a single-cycle strobe that marks the 25 MHz nibble clock. On each strobe edge the block takes one nibble and the frame-enable input and chooses a 5-bit code-group for it.

When a frame starts, the first two nibble slots are replaced by the start delimiter pair. When the frame ends, the stop delimiter pair is appended. At all other times between frames the block sends the idle group. Each code-group is shifted out most significant bit first, one bit per clock. The bit is XORed with an 11-bit linear feedback key stream and then drives a three-level MLT-3 state machine. The MLT-3 state appears on the two one-hot outputs `line_pos` and `line_neg`.

When `mode_100` is low, the block stops the strobe, holds the line at zero and returns every register to its start value. Selecting the mode again restarts the stream from the same known state.

Top module: `pcs100_tx_encoder`

## Requirements
- R1: While `mode_100` is high, `tx_clk_en` is high in exactly one cycle of every five. The first strobe falls in the fourth cycle after enable, so when sampled after the k-th enabled clock edge (k from 0) it is high exactly when k mod 5 = 3.
- R2: In a strobe slot where `tx_en` is low and no frame is closing, the code-group 11111 (idle) is chosen. The group sent before the first strobe after enable is also idle.
- R3: In the slot where `tx_en` is first seen high after idle, the group is 11000. The next slot always carries 10001, whatever `txd` and `tx_en` hold.
- R4: Inside a frame, each nibble is mapped by the 4B/5B data table: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R5: The first slot inside a frame with `tx_en` low carries 01101. The next slot carries 00111 even if `tx_en` has risen again, and the slot after that returns to idle or, if `tx_en` is high, to 11000.
- R6: A group chosen at the strobe edge is sent MSB first. Its bits are the code bits consumed at the five following clock edges.
- R7: Each code bit is XORed with the key k = s[10] XOR s[8] of an 11-bit register s. The register shifts left every enabled cycle with k entering bit 0, so the polynomial is x^11 + x^9 + 1. It starts from the nonzero seed `SEED` (default 11'h4D3) at reset and at every enable.
- R8: The line level is registered. A scrambled 1 at an edge moves it one step through 0, +1, 0, -1, 0, and a scrambled 0 holds it. `line_pos` marks +1 and `line_neg` marks -1. They are never high together, and the level never jumps between +1 and -1.
- R9: While `rst_n` is low or `mode_100` is low, `tx_clk_en` is 0, and after the next clock edge both line outputs are 0. `tx_en` and `txd` have no effect in this state, and re-enabling restarts the phase, framing and key stream from their start values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_100 | input | 1 | High selects 100 Mb/s operation; low disables the path |
| tx_en | input | 1 | Frame enable from the MAC, sampled on strobe edges |
| txd | input | 4 | Transmit nibble, sampled on strobe edges |
| tx_clk_en | output | 1 | 25 MHz nibble strobe, one cycle in five |
| line_pos | output | 1 | Line level is +1 |
| line_neg | output | 1 | Line level is -1 |

## Verification
Counting enabled edges from 0, the strobe is sampled after edge k and is due high when k mod 5 = 3. The nibble driven in that window is captured at edge k+1. Its five code bits are consumed at edges k+2 through k+6, and each one is visible as a step or no step of the registered line level sampled after that same edge. The bench therefore drives each nibble at the falling clock edge inside a strobe window and samples the line two time units after every rising edge. It recovers each code bit from whether the level moved, XORs off its own key stream started from the seed, and regroups the bits five at a time from edge 0. The first recovered group is the idle group sent before the first strobe, and each later group is compared with its table entry in order.

// File: rtl/pcs100_pkg.sv
package pcs100_pkg;

  localparam int NIB_W = 4;
  localparam int SYM_W = 5;

  typedef enum logic [1:0] {
    FR_IDLE   = 2'd0,
    FR_SEND_K = 2'd1,
    FR_DATA   = 2'd2,
    FR_SEND_R = 2'd3
  } fr_state_e;

  localparam logic [SYM_W-1:0] CG_IDLE = 5'b11111;
  localparam logic [SYM_W-1:0] CG_J    = 5'b11000;
  localparam logic [SYM_W-1:0] CG_K    = 5'b10001;
  localparam logic [SYM_W-1:0] CG_T    = 5'b01101;
  localparam logic [SYM_W-1:0] CG_R    = 5'b00111;

  // 4B/5B data code-groups
  function automatic logic [SYM_W-1:0] map_nibble(input logic [NIB_W-1:0] n);
    logic [SYM_W-1:0] c;
    case (n)
      4'h0: c = 5'b11110;
      4'h1: c = 5'b01001;
      4'h2: c = 5'b10100;
      4'h3: c = 5'b10101;
      4'h4: c = 5'b01010;
      4'h5: c = 5'b01011;
      4'h6: c = 5'b01110;
      4'h7: c = 5'b01111;
      4'h8: c = 5'b10010;
      4'h9: c = 5'b10011;
      4'hA: c = 5'b10110;
      4'hB: c = 5'b10111;
      4'hC: c = 5'b11010;
      4'hD: c = 5'b11011;
      4'hE: c = 5'b11100;
      default: c = 5'b11101;
    endcase
    return c;
  endfunction

  // MLT-3 step index: 0 -> level 0, 1 -> +1, 2 -> 0, 3 -> -1
  function automatic logic [1:0] mlt3_step(input logic [1:0] idx, input logic b);
    return b ? (idx + 2'd1) : idx;
  endfunction

endpackage

// File: rtl/pcs100_clkdiv.sv
module pcs100_clkdiv #(
  parameter int DIV = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic strobe
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q;
  logic          at_last;

  assign at_last = (phase_q == LAST);
  assign strobe  = en && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (!en)     phase_q <= '0;
    else if (at_last) phase_q <= '0;
    else              phase_q <= phase_q + 1'b1;
  end

  // R1: a strobe is never followed directly by another
  p_strobe_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);

  // R1: phase stays inside the divide range
  p_phase_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= LAST);

endmodule

// File: rtl/pcs100_framer.sv
module pcs100_framer
  import pcs100_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             strobe,
  input  logic             tx_en,
  input  logic [NIB_W-1:0] txd,
  output logic             code_bit
);
  fr_state_e        state_q, state_d;
  logic [SYM_W-1:0] shreg_q;
  logic [SYM_W-1:0] group_d;
  logic             load;

  assign load     = en && strobe;
  assign code_bit = shreg_q[SYM_W-1];

  always_comb begin
    state_d = state_q;
    group_d = CG_IDLE;
    case (state_q)
      FR_IDLE: begin
        if (tx_en) begin
          group_d = CG_J;
          state_d = FR_SEND_K;
        end
      end
      FR_SEND_K: begin
        group_d = CG_K;
        state_d = FR_DATA;
      end
      FR_DATA: begin
        if (tx_en) begin
          group_d = map_nibble(txd);
        end else begin
          group_d = CG_T;
          state_d = FR_SEND_R;
        end
      end
      default: begin
        group_d = CG_R;
        state_d = FR_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_IDLE;
      shreg_q <= CG_IDLE;
    end else if (!en) begin
      state_q <= FR_IDLE;
      shreg_q <= CG_IDLE;
    end else if (load) begin
      state_q <= state_d;
      shreg_q <= group_d;
    end else begin
      shreg_q <= {shreg_q[SYM_W-2:0], 1'b1};
    end
  end

  // R3: frame start loads the first start delimiter
  p_start_j_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && state_q == FR_IDLE && tx_en) |=> (shreg_q == CG_J));

  // R3: second slot always carries the second start delimiter
  p_then_k_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && state_q == FR_SEND_K) |=> (shreg_q == CG_K && state_q == FR_DATA));

  // R5: the closing slot after T is R, then back to idle
  p_then_r_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && state_q == FR_SEND_R) |=> (shreg_q == CG_R && state_q == FR_IDLE));

  // R2: idle slot with no frame sends idle
  p_idle_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && state_q == FR_IDLE && !tx_en) |=> (shreg_q == CG_IDLE));

  // R6: between loads the group moves one bit toward the MSB
  p_msb_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load) |=> (shreg_q[SYM_W-1] == $past(shreg_q[SYM_W-2])));

endmodule

// File: rtl/pcs100_scrambler.sv
module pcs100_scrambler #(
  parameter int          LEN  = 11,
  parameter int          TAP  = 9,
  parameter logic [LEN-1:0] SEED = 11'h4D3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic plain,
  output logic scr
);
  logic [LEN-1:0] lfsr_q;
  logic           key;

  assign key = lfsr_q[LEN-1] ^ lfsr_q[TAP-1];
  assign scr = plain ^ key;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   lfsr_q <= SEED;
    else if (!en) lfsr_q <= SEED;
    else          lfsr_q <= {lfsr_q[LEN-2:0], key};
  end

  // R7: the key register never reaches the all-zero lock-up state
  p_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

  // R7: while disabled the register sits at the seed
  p_seed_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (lfsr_q == SEED));

endmodule

// File: rtl/pcs100_mlt3.sv
module pcs100_mlt3
  import pcs100_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic bit_in,
  output logic pos,
  output logic neg
);
  logic [1:0] idx_q;

  assign pos = (idx_q == 2'd1);
  assign neg = (idx_q == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx_q <= 2'd0;
    else if (!en) idx_q <= 2'd0;
    else          idx_q <= mlt3_step(idx_q, bit_in);
  end

  // R8: the two level flags are exclusive
  p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pos && neg));

  // R8: no direct jump between the outer levels
  p_no_jump_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(($past(pos) && neg) || ($past(neg) && pos)));

  // R8: a zero bit holds the level
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !bit_in) |=> $stable(idx_q));

endmodule

// File: rtl/pcs100_tx_encoder.sv
module pcs100_tx_encoder
  import pcs100_pkg::*;
#(
  parameter int             LFSR_LEN = 11,
  parameter int             LFSR_TAP = 9,
  parameter logic [10:0]    SEED     = 11'h4D3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_100,
  input  logic             tx_en,
  input  logic [NIB_W-1:0] txd,
  output logic             tx_clk_en,
  output logic             line_pos,
  output logic             line_neg
);
  logic strobe;
  logic code_bit;
  logic scr_bit;

  pcs100_clkdiv #(.DIV(SYM_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (mode_100),
    .strobe (strobe)
  );

  pcs100_framer u_frm (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (mode_100),
    .strobe   (strobe),
    .tx_en    (tx_en),
    .txd      (txd),
    .code_bit (code_bit)
  );

  pcs100_scrambler #(
    .LEN  (LFSR_LEN),
    .TAP  (LFSR_TAP),
    .SEED (SEED[LFSR_LEN-1:0])
  ) u_scr (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (mode_100),
    .plain (code_bit),
    .scr   (scr_bit)
  );

  pcs100_mlt3 u_mlt (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (mode_100),
    .bit_in (scr_bit),
    .pos    (line_pos),
    .neg    (line_neg)
  );

  assign tx_clk_en = strobe;

  // R9: a disabled path drives the line to zero after one edge
  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_100 |=> (!line_pos && !line_neg));

  // R9: no nibble strobe while the mode is off
  p_no_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_100 |-> !tx_clk_en);

endmodule

// File: tb/sim_pcs100_tx_encoder.sv
module sim_pcs100_tx_encoder;
  localparam int          CLK_P = 8;
  localparam logic [10:0] SEED  = 11'h4D3;
  localparam int          NVEC  = 35;

  // {tx_en, txd, expected code-group}
  localparam logic [9:0] VEC [0:NVEC-1] = '{
    {1'b0,4'h0,5'b11111}, {1'b0,4'h3,5'b11111},
    {1'b1,4'h5,5'b11000}, {1'b1,4'h5,5'b10001},
    {1'b1,4'h5,5'b01011}, {1'b1,4'hD,5'b11011},
    {1'b1,4'h0,5'b11110}, {1'b1,4'h1,5'b01001},
    {1'b1,4'h2,5'b10100}, {1'b1,4'h3,5'b10101},
    {1'b1,4'h4,5'b01010}, {1'b1,4'h6,5'b01110},
    {1'b1,4'h7,5'b01111}, {1'b1,4'h8,5'b10010},
    {1'b1,4'h9,5'b10011}, {1'b1,4'hA,5'b10110},
    {1'b1,4'hB,5'b10111}, {1'b1,4'hC,5'b11010},
    {1'b1,4'hE,5'b11100}, {1'b1,4'hF,5'b11101},
    {1'b0,4'hF,5'b01101}, {1'b1,4'h7,5'b00111},
    {1'b1,4'h0,5'b11000}, {1'b1,4'h9,5'b10001},
    {1'b1,4'h2,5'b10100}, {1'b0,4'h0,5'b01101},
    {1'b0,4'h0,5'b00111}, {1'b0,4'h6,5'b11111},
    // second run after re-enable
    {1'b0,4'h0,5'b11111}, {1'b0,4'h0,5'b11111},
    {1'b1,4'hE,5'b11000}, {1'b1,4'hE,5'b10001},
    {1'b0,4'h1,5'b01101}, {1'b0,4'h0,5'b00111},
    {1'b0,4'h0,5'b11111}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_100 = 1'b0;
  logic       tx_en = 1'b0;
  logic [3:0] txd = 4'h0;
  logic       tx_clk_en, line_pos, line_neg;

  int nchk = 0;
  int nerr = 0;

  // decoder state
  bit          run = 1'b0;
  int          k, nb, ng, prev_lv, last_nz;
  logic [10:0] bn;
  logic [4:0]  cur;
  logic [4:0]  grp [0:63];

  pcs100_tx_encoder #(.SEED(SEED)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_100(mode_100), .tx_en(tx_en), .txd(txd),
    .tx_clk_en(tx_clk_en), .line_pos(line_pos), .line_neg(line_neg)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [4:0] c);
    if (c == 5'b11111) return "R2 idle";
    if (c == 5'b11000 || c == 5'b10001) return "R3 start delimiter";
    if (c == 5'b01101 || c == 5'b00111) return "R5 end delimiter";
    return "R4 data map";
  endfunction

  // Line decoder: R1 strobe phase, R8 level order, R6/R7 bit recovery
  always @(posedge clk) begin
    if (run) begin
      int lv, exp_lv;
      logic s, key, b;
      #2;
      chk(tx_clk_en == ((k % 5) == 3), "R1 strobe phase", int'(tx_clk_en), int'((k % 5) == 3));
      chk(!(line_pos && line_neg), "R8 exclusive levels", int'({line_pos, line_neg}), 1);
      lv = line_pos ? 1 : (line_neg ? -1 : 0);
      s  = (lv != prev_lv);
      if (s) begin
        exp_lv = (prev_lv != 0) ? 0 : -last_nz;
        chk(lv == exp_lv, "R8 level order", lv, exp_lv);
        if (lv != 0) last_nz = lv;
      end
      prev_lv = lv;
      key = bn[10] ^ bn[8];
      bn  = {bn[9:0], key};
      b   = s ^ key;
      cur = {cur[3:0], b};
      nb++;
      if (nb == 5) begin
        if (ng < 64) grp[ng] = cur;
        ng++;
        nb = 0;
      end
      k++;
    end
  end

  task automatic start_decode();
    k = 0; nb = 0; ng = 0; prev_lv = 0; last_nz = -1; bn = SEED; cur = '0;
    run = 1'b1;
  endtask

  task automatic drive_seq(input int first, input int count);
    for (int i = first; i < first + count; i++) begin
      do @(negedge clk); while (!tx_clk_en);
      tx_en = VEC[i][9];
      txd   = VEC[i][8:5];
    end
    do @(negedge clk); while (!tx_clk_en);
    tx_en = 1'b0;
    txd   = 4'h0;
    repeat (12) @(negedge clk);
    run = 1'b0;
  endtask

  task automatic compare_seq(input int first, input int count);
    chk(ng >= count + 1, "R6 group count", ng, count + 1);
    chk(grp[0] == 5'b11111, "R2 idle before first strobe", int'(grp[0]), 5'h1F);
    for (int i = 0; i < count; i++) begin
      if (i + 1 < ng)
        chk(grp[i+1] == VEC[first+i][4:0], tag_of(VEC[first+i][4:0]),
            int'(grp[i+1]), int'(VEC[first+i][4:0]));
    end
  endtask

  initial begin
    #(CLK_P * 50000);
    nerr++;
    nchk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    chk(!tx_clk_en && !line_pos && !line_neg, "R9 reset outputs",
        int'({tx_clk_en, line_pos, line_neg}), 0);
    rst_n = 1'b1;
    // R9: mode off, frame inputs ignored
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      tx_en = i[0];
      txd   = 4'(i);
      chk(!tx_clk_en && !line_pos && !line_neg, "R9 disabled ignores tx_en",
          int'({tx_clk_en, line_pos, line_neg}), 0);
    end
    // table walk: R2 R3 R4 R5, decoded through R6 R7 R8
    @(negedge clk);
    tx_en = 1'b0;
    txd = 4'h0;
    mode_100 = 1'b1;
    start_decode();
    drive_seq(0, 28);
    compare_seq(0, 28);
    // R9: disable mid-frame
    tx_en = 1'b1;
    txd = 4'hA;
    repeat (17) @(negedge clk);
    mode_100 = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!tx_clk_en && !line_pos && !line_neg, "R9 disable mid-frame",
          int'({tx_clk_en, line_pos, line_neg}), 0);
    end
    // R9: re-enable restarts phase, framing and seed; short frame R5
    tx_en = 1'b0;
    mode_100 = 1'b1;
    start_decode();
    drive_seq(28, 7);
    compare_seq(28, 7);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule